// File: doc/BRIEF.md
# Shuffle-Buffer Bus Address Obfuscator

This block sits between a single on-chip requester and an external block-organised memory. It keeps a small set of whole blocks on chip in a shuffle buffer. A remap table records, for every logical block that is not on chip, the physical slot that holds it. A request for an on-chip block is served locally and causes no bus activity. A request for an off-chip block reads that block from its current slot. A block chosen at random from the buffer is then written back into the slot that was just freed. As a result, a logical address stream that repeats does not produce a repeating physical address stream on the memory bus.

After reset the remap table is the identity. A fill phase then copies the first `BUF_DEPTH` blocks on chip and raises `ready`. The buffer holds one entry more than `BUF_DEPTH`. That spare entry, the hole, receives the incoming block of a miss. The victim is drawn from the other entries by an internal LFSR, which redraws until the index is usable, and the victim's entry becomes the next hole. The memory port returns read data in the cycle after `mem_rd`.

Top module: `obf_shuffle_top`

## Requirements
- R1: After reset the block issues reads of slots 0 to BUF_DEPTH-1 in ascending order and no writes. `ready` stays low until these reads complete, then stays high. A request presented before `ready` is ignored.
- R2: A request for a block held on chip gets `resp_valid` in the cycle after acceptance. During that request `busy` stays low and there is no memory read or write.
- R3: A request for an off-chip block reads the slot that the remap table holds for it. At reset, block n is held in slot n.
- R4: Each miss writes exactly one block back, to the same slot address that the miss read. That block was on chip before the miss and is not the requested block.
- R5: The remap table follows every relocation. A block evicted into slot s is read from slot s when it is next requested.
- R6: The victim is always a valid buffer entry and never the entry that receives the incoming block.
- R7: `busy` is high from the cycle after a miss is accepted until `resp_valid`. Each miss makes one read and one write. Requests presented while `busy` is high have no effect.
- R8: A request with `req_we` set replaces the block contents with `req_wdata` and returns that value. Later reads and evictions of the block carry the new contents.
- R9: A read request returns the current contents of the requested block.
- R10: A seed of zero is replaced by a non-zero LFSR state, so victim selection still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed | input | 16 | LFSR seed, loaded while reset is high |
| req_valid | input | 1 | Request strobe, taken when ready and not busy |
| req_lblk | input | ADDR_W | Logical block number |
| req_we | input | 1 | Request writes the block |
| req_wdata | input | DATA_W | Write contents |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DATA_W | Block contents after the request |
| ready | output | 1 | Fill phase complete |
| busy | output | 1 | Miss in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Physical slot address |
| mem_wdata | output | DATA_W | Evicted block contents |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_rd |

## Verification
The assertions assume that the memory returns the data of the addressed slot one cycle after `mem_rd`, and that `req_lblk` is always below `NUM_BLOCKS`. The bench memory is a registered array with exactly that latency. Every request number the bench generates is reduced modulo the block count. The bench does not try to predict the random victim. It gives every block unique contents and identifies the victim from the written data, which keeps it independent of the LFSR. Each request is a one-cycle pulse, and the only requests raised during fill or a miss are deliberate ones that must be ignored.

// File: rtl/obf_pkg.sv
package obf_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    typedef enum logic [3:0] {
        ST_FILL_RD,
        ST_FILL_CAP,
        ST_IDLE,
        ST_LOOKUP,
        ST_RD,
        ST_CAP,
        ST_PICK,
        ST_WR,
        ST_UPD
    } obf_state_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

    function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
        return (s == '0) ? LFSR_W'(1) : s;
    endfunction

endpackage

// File: rtl/obf_victim_pick.sv
module obf_victim_pick
    import obf_pkg::*;
#(
    parameter int ENTRIES = 5,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LFSR_W-1:0] seed,
    input  logic [IDX_W-1:0]  excl,
    output logic [IDX_W-1:0]  cand_idx,
    output logic              cand_ok
);
    localparam logic [IDX_W:0] ENT_L = (IDX_W+1)'(ENTRIES);

    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= seed_fix(seed);
        else     lfsr_q <= lfsr_step(lfsr_q);
    end

    assign cand_idx = lfsr_q[IDX_W-1:0];
    assign cand_ok  = ({1'b0, cand_idx} < ENT_L) && (cand_idx != excl);

    // R10
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
endmodule

// File: rtl/obf_remap_table.sv
module obf_remap_table #(
    parameter int NUM_BLOCKS = 16,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_lblk,
    output logic [ADDR_W-1:0] rd_slot,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_lblk,
    input  logic [ADDR_W-1:0] wr_slot
);
    logic [ADDR_W-1:0] map_q [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BLOCKS; i++) map_q[i] <= ADDR_W'(i);
        end else if (wr_en) begin
            map_q[wr_lblk] <= wr_slot;
        end
    end

    assign rd_slot = map_q[rd_lblk];
endmodule

// File: rtl/obf_shuffle_buf.sv
module obf_shuffle_buf #(
    parameter int ENTRIES = 5,
    parameter int IDX_W   = 3,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_tag_en,
    input  logic [ADDR_W-1:0] wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [DATA_W-1:0] a_data,
    output logic [ADDR_W-1:0] a_tag,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [DATA_W-1:0] b_data,
    input  logic              look_en,
    input  logic [ADDR_W-1:0] look_tag,
    input  logic [IDX_W-1:0]  look_excl,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [DATA_W-1:0] data_q [ENTRIES];
    logic [ADDR_W-1:0] tag_q  [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '0;
        end else if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            if (wr_tag_en) tag_q[wr_idx] <= wr_tag;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = look_en && (tag_q[e] == look_tag) && (IDX_W'(e) != look_excl);
    end

    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < ENTRIES; e++) if (match[e]) hit_idx = IDX_W'(e);
    end

    assign hit    = |match;
    assign a_data = data_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign b_data = data_q[b_idx];

    // R5
    tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
endmodule

// File: rtl/obf_shuffle_top.sv
module obf_shuffle_top
    import obf_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int BUF_DEPTH  = 4,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LFSR_W-1:0]             seed,
    input  logic                          req_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0] req_lblk,
    input  logic                          req_we,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          resp_valid,
    output logic [DATA_W-1:0]             resp_rdata,
    output logic                          ready,
    output logic                          busy,
    output logic                          mem_rd,
    output logic                          mem_wr,
    output logic [$clog2(NUM_BLOCKS)-1:0] mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata
);
    localparam int ADDR_W  = $clog2(NUM_BLOCKS);
    localparam int ENTRIES = BUF_DEPTH + 1;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_FILL = IDX_W'(BUF_DEPTH - 1);
    localparam logic [IDX_W-1:0] FIRST_HOLE = IDX_W'(BUF_DEPTH);

    obf_state_e        state_q;
    logic [IDX_W-1:0]  fill_cnt_q, hole_q, vic_q;
    logic              fill_done_q, we_q;
    logic [ADDR_W-1:0] lblk_q, slot_q;
    logic [DATA_W-1:0] wdata_q;

    logic              accept, hit;
    logic [IDX_W-1:0]  hit_idx, cand_idx, b_idx;
    logic              cand_ok;
    logic [ADDR_W-1:0] tbl_slot, a_tag;
    logic [DATA_W-1:0] a_data, b_data;

    logic              bw_en, bw_tag_en;
    logic [IDX_W-1:0]  bw_idx;
    logic [ADDR_W-1:0] bw_tag;
    logic [DATA_W-1:0] bw_data;

    assign accept = fill_done_q && (state_q == ST_IDLE) && req_valid;
    assign b_idx  = (state_q == ST_IDLE) ? hit_idx : hole_q;

    obf_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst(rst), .seed(seed), .excl(hole_q),
        .cand_idx(cand_idx), .cand_ok(cand_ok)
    );

    obf_remap_table #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst(rst), .rd_lblk(lblk_q), .rd_slot(tbl_slot),
        .wr_en(state_q == ST_UPD), .wr_lblk(a_tag), .wr_slot(slot_q)
    );

    obf_shuffle_buf #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst(rst),
        .wr_en(bw_en), .wr_idx(bw_idx), .wr_tag_en(bw_tag_en), .wr_tag(bw_tag), .wr_data(bw_data),
        .a_idx(vic_q), .a_data(a_data), .a_tag(a_tag),
        .b_idx(b_idx), .b_data(b_data),
        .look_en(fill_done_q), .look_tag(req_lblk), .look_excl(hole_q),
        .hit(hit), .hit_idx(hit_idx)
    );

    always_comb begin
        bw_en = 1'b0; bw_tag_en = 1'b0; bw_idx = hole_q; bw_tag = lblk_q; bw_data = mem_rdata;
        case (state_q)
            ST_FILL_CAP: begin
                bw_en = 1'b1; bw_tag_en = 1'b1; bw_idx = fill_cnt_q; bw_tag = ADDR_W'(fill_cnt_q);
            end
            ST_CAP: begin
                bw_en = 1'b1; bw_tag_en = 1'b1;
            end
            ST_UPD: begin
                bw_en = we_q; bw_data = wdata_q;
            end
            ST_IDLE: begin
                bw_en = accept && hit && req_we; bw_idx = hit_idx; bw_data = req_wdata;
            end
            default: ;
        endcase
    end

    assign mem_rd    = (state_q == ST_FILL_RD) || (state_q == ST_RD);
    assign mem_wr    = (state_q == ST_WR);
    assign mem_addr  = (state_q == ST_FILL_RD) ? ADDR_W'(fill_cnt_q) : slot_q;
    assign mem_wdata = a_data;
    assign ready     = fill_done_q;
    assign busy      = fill_done_q && (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_FILL_RD;
            fill_cnt_q  <= '0;
            fill_done_q <= 1'b0;
            hole_q      <= FIRST_HOLE;
            vic_q       <= '0;
            lblk_q      <= '0;
            slot_q      <= '0;
            we_q        <= 1'b0;
            wdata_q     <= '0;
            resp_valid  <= 1'b0;
            resp_rdata  <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_FILL_RD:  state_q <= ST_FILL_CAP;
                ST_FILL_CAP: begin
                    if (fill_cnt_q == LAST_FILL) begin
                        fill_done_q <= 1'b1;
                        state_q     <= ST_IDLE;
                    end else begin
                        fill_cnt_q <= fill_cnt_q + 1'b1;
                        state_q    <= ST_FILL_RD;
                    end
                end
                ST_IDLE: begin
                    if (accept) begin
                        lblk_q  <= req_lblk;
                        we_q    <= req_we;
                        wdata_q <= req_wdata;
                        if (hit) begin
                            resp_valid <= 1'b1;
                            resp_rdata <= req_we ? req_wdata : b_data;
                        end else begin
                            state_q <= ST_LOOKUP;
                        end
                    end
                end
                ST_LOOKUP: begin
                    slot_q  <= tbl_slot;
                    state_q <= ST_RD;
                end
                ST_RD:  state_q <= ST_CAP;
                ST_CAP: state_q <= ST_PICK;
                ST_PICK: begin
                    if (cand_ok) begin
                        vic_q   <= cand_idx;
                        state_q <= ST_WR;
                    end
                end
                ST_WR: state_q <= ST_UPD;
                ST_UPD: begin
                    resp_valid <= 1'b1;
                    resp_rdata <= we_q ? wdata_q : b_data;
                    hole_q     <= vic_q;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    logic [ADDR_W-1:0] last_rd_addr_q;
    always_ff @(posedge clk) begin
        if (rst) last_rd_addr_q <= '0;
        else if (mem_rd) last_rd_addr_q <= mem_addr;
    end

    // R1
    no_wr_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !mem_wr);
    // R1
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (!mem_rd && !mem_wr));
    // R4
    wr_same_slot_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr == last_rd_addr_q));
    // R6
    victim_not_incoming_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (vic_q != hole_q));
    // R7
    resp_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !busy);
endmodule

// File: tb/obf_shuffle_top_tb_top.sv
module obf_shuffle_top_tb_top;
    localparam int NB = 16;
    localparam int BD = 4;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   seed = 16'h0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_lblk = '0;
    logic          req_we = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          resp_valid, ready, busy, mem_rd, mem_wr;
    logic [DW-1:0] resp_rdata, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    always #5 clk = ~clk;

    obf_shuffle_top #(.NUM_BLOCKS(NB), .BUF_DEPTH(BD), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .seed(seed),
        .req_valid(req_valid), .req_lblk(req_lblk), .req_we(req_we), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .ready(ready), .busy(busy),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [DW-1:0] phys [NB];
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= phys[mem_addr];
        if (mem_wr) phys[mem_addr] <= mem_wdata;
    end

    // behavioural model: contents, slot and residency per logical block
    logic [DW-1:0] bdata [NB];
    int            bslot [NB];
    bit            bres  [NB];
    int n_cmp = 0;
    int n_bad = 0;
    int wcount = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic do_reset(input logic [15:0] s);
        int idx;
        rst = 1'b1; seed = s; req_valid = 1'b0;
        for (int i = 0; i < NB; i++) begin
            phys[i] = 32'hA500_0000 | i; bdata[i] = 32'hA500_0000 | i; bslot[i] = i; bres[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(!ready && !busy && !resp_valid && !mem_wr, "R1", "reset state", {ready, busy, resp_valid, mem_wr}, 0);
        rst = 1'b0;
        req_valid = 1'b1; req_lblk = AW'(9); req_we = 1'b1; req_wdata = 32'hDEAD_0009;
        idx = 0;
        for (int c = 0; c < 40; c++) begin
            if (ready) break;
            check(!mem_wr && !busy && !resp_valid, "R1", "quiet during fill", {mem_wr, busy, resp_valid}, 0);
            if (mem_rd) begin
                check(mem_addr == AW'(idx), "R1", "fill slot", mem_addr, idx);
                idx++;
            end
            @(negedge clk);
        end
        req_valid = 1'b0; req_we = 1'b0;
        check(ready && idx == BD, "R1", "fill count / ready", {ready, 8'(idx)}, {1'b1, 8'(BD)});
        for (int i = 0; i < BD; i++) bres[i] = 1'b1;
        @(negedge clk);
        check(!busy && !resp_valid && !mem_rd && !mem_wr, "R1", "request before ready ignored",
              {busy, resp_valid, mem_rd, mem_wr}, 0);
    endtask

    task automatic do_req(input int L, input bit we, input logic [DW-1:0] wd);
        bit hit, done, found;
        int nrd, nwr, vic;
        logic [DW-1:0] exp;
        hit = bres[L];
        exp = we ? wd : bdata[L];
        req_valid = 1'b1; req_lblk = AW'(L); req_we = we; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        if (hit) begin
            check(resp_valid && !busy && !mem_rd && !mem_wr, "R2", "hit timing / no traffic",
                  {resp_valid, busy, mem_rd, mem_wr}, 4'b1000);
            check(resp_rdata == exp, we ? "R8" : "R9", "hit data", resp_rdata, exp);
            if (we) bdata[L] = wd;
        end else begin
            done = 0; found = 0; nrd = 0; nwr = 0; vic = 0;
            for (int c = 0; c < 60; c++) begin
                if (c == 1) begin req_valid = 1'b1; req_lblk = AW'((L + 1) % NB); end
                if (c == 2) req_valid = 1'b0;
                if (resp_valid) begin done = 1; break; end
                check(busy, "R7", "busy during miss", busy, 1);
                if (mem_rd) begin
                    nrd++;
                    check(mem_addr == AW'(bslot[L]), (bslot[L] != L) ? "R5" : "R3", "miss read slot", mem_addr, bslot[L]);
                end
                if (mem_wr) begin
                    nwr++;
                    check(mem_addr == AW'(bslot[L]), "R4", "write-back slot", mem_addr, bslot[L]);
                    for (int v = 0; v < NB; v++)
                        if (bres[v] && v != L && bdata[v] == mem_wdata) begin found = 1; vic = v; end
                    check(found, "R6", "victim is another resident block", mem_wdata, 0);
                end
                @(negedge clk);
            end
            check(done && !busy, "R7", "miss completes", {done, busy}, 2'b10);
            check(nrd == 1 && nwr == 1, "R7", "one read one write", {8'(nrd), 8'(nwr)}, 16'h0101);
            check(resp_rdata == exp, we ? "R8" : "R9", "miss data", resp_rdata, exp);
            if (found) begin bslot[vic] = bslot[L]; bres[vic] = 1'b0; end
            bres[L] = 1'b1;
            if (we) bdata[L] = wd;
        end
        @(negedge clk);
        check(!resp_valid && !busy && !mem_rd && !mem_wr, "R7", "quiet after request",
              {resp_valid, busy, mem_rd, mem_wr}, 0);
    endtask

    function automatic logic [DW-1:0] next_wd(input int L);
        wcount++;
        return 32'hC000_0000 | (wcount << 8) | L;
    endfunction

    initial begin
        do_reset(16'hACE1);
        do_req(2, 1'b0, 0);
        do_req(1, 1'b1, next_wd(1));
        do_req(1, 1'b0, 0);
        for (int i = 0; i < 40; i++) begin
            int L;
            L = (i * 5 + 4) % NB;
            do_req(L, (i % 4) == 1, next_wd(L));
        end
        // R10: zero seed still yields working victim selection
        do_reset(16'h0000);
        for (int i = 0; i < 12; i++) begin
            int L;
            L = (i * 3 + 5) % NB;
            do_req(L, (i % 3) == 0, next_wd(L));
        end
        check(1'b1, "R10", "zero seed run finished", 0, 0);
        finish_run();
    end
endmodule